// File: doc/BRIEF.md
# TLB-Backed Page Address Translator

This block turns an 8-bit virtual byte address into a physical byte address for one running process. The address splits into a 3-bit virtual page number and a 5-bit offset inside a 32-byte page. Eight page descriptors, held in registers and loaded through a write port, each give a physical frame number and a set of flag bits. A four-entry fully associative translation cache sits in front of that table. A request first searches the cache by page number. When it hits, the physical address is returned on the next cycle. When it misses, the controller spends one cycle reading the descriptor. A present descriptor yields an address and is copied into the cache. An absent one yields a page fault.

A write to a read-only page yields a protection fault. This fault is reported separately from the page fault. Every access that completes without a fault marks its descriptor as used, and a write also marks it as dirty. When software switches to another process's table, it pulses the flush input to empty the cache.

The controller has two states. IDLE accepts a request. It moves to WALK on a cache miss and stays in IDLE on a hit or when no request is offered. WALK reads the descriptor, answers, and always returns to IDLE on the next clock.

Top module: `pxl_xlate`

## Requirements
- R1: After reset `resp_valid` and `busy` are 0, and the cache holds nothing, so the first access to any page answers with `resp_hit` = 0.
- R2: A translated address is the frame number in bits 7:5 and the unchanged request offset in bits 4:0. For example, page 1 mapped to frame 2 turns 0x2A into 0x4A.
- R3: An access to a descriptor whose present bit is 0 answers with `resp_page_fault` = 1 and `resp_paddr` = 0. It does not fill the cache, so a repeat access misses again.
- R4: A cache hit answers on the cycle after acceptance with `resp_hit` = 1. It takes the frame from the cache without reading the table, so a descriptor rewritten without a flush still returns the cached frame.
- R5: A miss holds `busy` high for the one cycle after acceptance and answers one cycle later with `resp_hit` = 0. A present descriptor is copied into the cache, so the next access to that page hits.
- R6: A request offered while `busy` is 1 is ignored. It produces no response and does not fill the cache.
- R7: Cache fills go to slots in rotating order 0,1,2,3,0,…, and the order restarts at slot 0 after a flush. The fifth distinct page filled after a flush evicts the first one.
- R8: A write to a present page whose writable flag is 0 answers with `resp_prot_fault` = 1, `resp_page_fault` = 0 and `resp_paddr` = 0. This applies on a hit and on a miss, and a miss still fills the cache.
- R9: A fault-free access sets the descriptor's referenced flag, and a fault-free write also sets its modified flag. A faulting access changes neither flag. A descriptor write clears both flags and stores the lock flag, which reads back unchanged.
- R10: A `tlb_flush` pulse empties the cache, so the next access to any page misses. A flush in the same cycle as a fill wins, and the page is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_we | input | 1 | Write one page descriptor |
| pt_widx | input | 3 | Descriptor index to write |
| pt_wpfn | input | 3 | Frame number to store |
| pt_wpresent | input | 1 | Present flag to store |
| pt_wwritable | input | 1 | Writable flag to store (0 = read-only) |
| pt_wlock | input | 1 | Lock flag to store |
| pt_qidx | input | 3 | Descriptor index for flag readback |
| pt_qref | output | 1 | Referenced flag of descriptor `pt_qidx` |
| pt_qmod | output | 1 | Modified flag of descriptor `pt_qidx` |
| pt_qlock | output | 1 | Lock flag of descriptor `pt_qidx` |
| tlb_flush | input | 1 | Empty the translation cache |
| req_valid | input | 1 | Translation request, taken when `busy` is 0 |
| req_addr | input | 8 | Virtual byte address |
| req_write | input | 1 | Request is a write access |
| busy | output | 1 | Table read in progress; requests are ignored |
| resp_valid | output | 1 | A response is presented this cycle |
| resp_paddr | output | 8 | Physical address (0 when faulted) |
| resp_hit | output | 1 | Response was served from the cache |
| resp_page_fault | output | 1 | Descriptor not present |
| resp_prot_fault | output | 1 | Write to a read-only page |

## Verification
Some checks hold on every cycle. A response keeps the accepted offset in its low bits. A faulted response carries a zero address and never raises both faults at once. A hit response always follows an accepted request by one cycle. Every busy cycle is followed by a non-hit response with `busy` low again. Other behaviour needs the bench's scenarios. These are the cached frame outliving a table rewrite, the rotating eviction order, the fill skipped after a fault or a same-cycle flush, the ignored stray request, and the flag bookkeeping.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

    typedef enum logic [0:0] {
        PXL_IDLE = 1'b0,
        PXL_WALK = 1'b1
    } pxl_state_e;

    typedef struct packed {
        logic present;
        logic writable;
        logic locked;
    } pxl_flags_t;

endpackage

// File: rtl/pxl_page_table.sv
module pxl_page_table
    import pxl_pkg::*;
#(
    parameter int unsigned VPN_W = 3,
    parameter int unsigned PFN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_idx,
    input  logic [PFN_W-1:0] wr_pfn,
    input  pxl_flags_t       wr_flags,
    input  logic [VPN_W-1:0] rd_idx,
    output logic [PFN_W-1:0] rd_pfn,
    output pxl_flags_t       rd_flags,
    input  logic             touch_en,
    input  logic [VPN_W-1:0] touch_idx,
    input  logic             touch_write,
    input  logic [VPN_W-1:0] q_idx,
    output logic             q_ref,
    output logic             q_mod,
    output logic             q_lock
);
    localparam int unsigned N_PAGES = 1 << VPN_W;

    logic [PFN_W-1:0] pfn_q   [N_PAGES];
    pxl_flags_t       flags_q [N_PAGES];
    logic [N_PAGES-1:0] ref_q;
    logic [N_PAGES-1:0] mod_q;

    for (genvar i = 0; i < N_PAGES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pfn_q[i]   <= '0;
                flags_q[i] <= '0;
                ref_q[i]   <= 1'b0;
                mod_q[i]   <= 1'b0;
            end else if (wr_en && wr_idx == VPN_W'(i)) begin
                pfn_q[i]   <= wr_pfn;
                flags_q[i] <= wr_flags;
                ref_q[i]   <= 1'b0;
                mod_q[i]   <= 1'b0;
            end else if (touch_en && touch_idx == VPN_W'(i)) begin
                ref_q[i] <= 1'b1;
                if (touch_write) begin
                    mod_q[i] <= 1'b1;
                end
            end
        end
    end

    assign rd_pfn   = pfn_q[rd_idx];
    assign rd_flags = flags_q[rd_idx];
    assign q_ref    = ref_q[q_idx];
    assign q_mod    = mod_q[q_idx];
    assign q_lock   = flags_q[q_idx].locked;

endmodule

// File: rtl/pxl_tlb.sv
module pxl_tlb #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned VPN_W   = 3,
    parameter int unsigned PFN_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    output logic             hit_writable,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_writable
);
    localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [ENTRIES-1:0] wr_q;
    logic [PTR_W-1:0]   ptr_q;
    logic [ENTRIES-1:0] match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                vpn_q[i]   <= '0;
                pfn_q[i]   <= '0;
                wr_q[i]    <= 1'b0;
            end else if (flush) begin
                valid_q[i] <= 1'b0;
            end else if (fill_en && ptr_q == PTR_W'(i)) begin
                valid_q[i] <= 1'b1;
                vpn_q[i]   <= fill_vpn;
                pfn_q[i]   <= fill_pfn;
                wr_q[i]    <= fill_writable;
            end
        end
        assign match[i] = valid_q[i] && (vpn_q[i] == look_vpn);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr_q <= '0;
        end else if (fill_en) begin
            ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_comb begin
        hit_pfn      = '0;
        hit_writable = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_pfn      = hit_pfn | pfn_q[i];
                hit_writable = hit_writable | wr_q[i];
            end
        end
    end

    assign hit = |match;

endmodule

// File: rtl/pxl_ctrl.sv
module pxl_ctrl
    import pxl_pkg::*;
#(
    parameter int unsigned VPN_W = 3,
    parameter int unsigned OFF_W = 5,
    parameter int unsigned PFN_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VPN_W-1:0]       req_vpn,
    input  logic [OFF_W-1:0]       req_off,
    input  logic                   req_write,
    input  logic                   tlb_hit,
    input  logic [PFN_W-1:0]       tlb_pfn,
    input  logic                   tlb_writable,
    input  logic [PFN_W-1:0]       pt_pfn,
    input  logic                   pt_present,
    input  logic                   pt_writable,
    output logic [VPN_W-1:0]       walk_vpn,
    output logic                   fill_en,
    output logic                   touch_en,
    output logic [VPN_W-1:0]       touch_idx,
    output logic                   touch_write,
    output logic                   busy,
    output logic                   resp_valid,
    output logic [PFN_W+OFF_W-1:0] resp_paddr,
    output logic                   resp_hit,
    output logic                   resp_page_fault,
    output logic                   resp_prot_fault
);
    localparam int unsigned PA_W = PFN_W + OFF_W;

    pxl_state_e       state_q, state_d;
    logic [VPN_W-1:0] lat_vpn_q;
    logic [OFF_W-1:0] lat_off_q;
    logic             lat_write_q;
    logic             lat_load;

    logic             v_d, hit_d, pf_d, prot_d;
    logic [PA_W-1:0]  pa_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PXL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        lat_load    = 1'b0;
        fill_en     = 1'b0;
        touch_en    = 1'b0;
        touch_idx   = req_vpn;
        touch_write = req_write;
        v_d         = 1'b0;
        hit_d       = 1'b0;
        pf_d        = 1'b0;
        prot_d      = 1'b0;
        pa_d        = '0;
        unique case (state_q)
            PXL_IDLE: begin
                if (req_valid) begin
                    if (tlb_hit) begin
                        v_d      = 1'b1;
                        hit_d    = 1'b1;
                        prot_d   = req_write && !tlb_writable;
                        touch_en = !prot_d;
                        pa_d     = prot_d ? '0 : {tlb_pfn, req_off};
                    end else begin
                        lat_load = 1'b1;
                        state_d  = PXL_WALK;
                    end
                end
            end
            PXL_WALK: begin
                touch_idx   = lat_vpn_q;
                touch_write = lat_write_q;
                v_d         = 1'b1;
                pf_d        = !pt_present;
                prot_d      = pt_present && lat_write_q && !pt_writable;
                fill_en     = pt_present;
                touch_en    = pt_present && !prot_d;
                pa_d        = (pf_d || prot_d) ? '0 : {pt_pfn, lat_off_q};
                state_d     = PXL_IDLE;
            end
            default: state_d = PXL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_vpn_q   <= '0;
            lat_off_q   <= '0;
            lat_write_q <= 1'b0;
        end else if (lat_load) begin
            lat_vpn_q   <= req_vpn;
            lat_off_q   <= req_off;
            lat_write_q <= req_write;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid      <= 1'b0;
            resp_hit        <= 1'b0;
            resp_page_fault <= 1'b0;
            resp_prot_fault <= 1'b0;
            resp_paddr      <= '0;
        end else begin
            resp_valid      <= v_d;
            resp_hit        <= hit_d;
            resp_page_fault <= pf_d;
            resp_prot_fault <= prot_d;
            resp_paddr      <= pa_d;
        end
    end

    assign busy     = (state_q == PXL_WALK);
    assign walk_vpn = lat_vpn_q;

endmodule

// File: rtl/pxl_xlate.sv
module pxl_xlate
    import pxl_pkg::*;
#(
    parameter int unsigned VPN_W   = 3,
    parameter int unsigned OFF_W   = 5,
    parameter int unsigned PFN_W   = 3,
    parameter int unsigned TLB_N   = 4,
    localparam int unsigned VA_W   = VPN_W + OFF_W,
    localparam int unsigned PA_W   = PFN_W + OFF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pt_we,
    input  logic [VPN_W-1:0] pt_widx,
    input  logic [PFN_W-1:0] pt_wpfn,
    input  logic            pt_wpresent,
    input  logic            pt_wwritable,
    input  logic            pt_wlock,
    input  logic [VPN_W-1:0] pt_qidx,
    output logic            pt_qref,
    output logic            pt_qmod,
    output logic            pt_qlock,
    input  logic            tlb_flush,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_addr,
    input  logic            req_write,
    output logic            busy,
    output logic            resp_valid,
    output logic [PA_W-1:0] resp_paddr,
    output logic            resp_hit,
    output logic            resp_page_fault,
    output logic            resp_prot_fault
);
    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    logic             tlb_hit, tlb_writable;
    logic [PFN_W-1:0] tlb_pfn, pt_pfn;
    pxl_flags_t       pt_flags, wr_flags;
    logic [VPN_W-1:0] walk_vpn, touch_idx;
    logic             fill_en, touch_en, touch_write;

    assign req_vpn  = req_addr[VA_W-1:OFF_W];
    assign req_off  = req_addr[OFF_W-1:0];
    assign wr_flags = '{present: pt_wpresent, writable: pt_wwritable, locked: pt_wlock};

    pxl_page_table #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (pt_we),
        .wr_idx      (pt_widx),
        .wr_pfn      (pt_wpfn),
        .wr_flags    (wr_flags),
        .rd_idx      (walk_vpn),
        .rd_pfn      (pt_pfn),
        .rd_flags    (pt_flags),
        .touch_en    (touch_en),
        .touch_idx   (touch_idx),
        .touch_write (touch_write),
        .q_idx       (pt_qidx),
        .q_ref       (pt_qref),
        .q_mod       (pt_qmod),
        .q_lock      (pt_qlock)
    );

    pxl_tlb #(.ENTRIES(TLB_N), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_tlb (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (tlb_flush),
        .look_vpn      (req_vpn),
        .hit           (tlb_hit),
        .hit_pfn       (tlb_pfn),
        .hit_writable  (tlb_writable),
        .fill_en       (fill_en),
        .fill_vpn      (walk_vpn),
        .fill_pfn      (pt_pfn),
        .fill_writable (pt_flags.writable)
    );

    pxl_ctrl #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_vpn         (req_vpn),
        .req_off         (req_off),
        .req_write       (req_write),
        .tlb_hit         (tlb_hit),
        .tlb_pfn         (tlb_pfn),
        .tlb_writable    (tlb_writable),
        .pt_pfn          (pt_pfn),
        .pt_present      (pt_flags.present),
        .pt_writable     (pt_flags.writable),
        .walk_vpn        (walk_vpn),
        .fill_en         (fill_en),
        .touch_en        (touch_en),
        .touch_idx       (touch_idx),
        .touch_write     (touch_write),
        .busy            (busy),
        .resp_valid      (resp_valid),
        .resp_paddr      (resp_paddr),
        .resp_hit        (resp_hit),
        .resp_page_fault (resp_page_fault),
        .resp_prot_fault (resp_prot_fault)
    );

endmodule

// File: rtl/pxl_xlate_chk.sv
module pxl_xlate_chk #(
    parameter int unsigned VA_W  = 8,
    parameter int unsigned PA_W  = 8,
    parameter int unsigned OFF_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_addr,
    input logic            busy,
    input logic            resp_valid,
    input logic [PA_W-1:0] resp_paddr,
    input logic            resp_hit,
    input logic            resp_page_fault,
    input logic            resp_prot_fault
);
    logic [OFF_W-1:0] acc_off_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_off_q <= '0;
        end else if (req_valid && !busy) begin
            acc_off_q <= req_addr[OFF_W-1:0];
        end
    end

    // R2: a clean response keeps the accepted offset
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_page_fault && !resp_prot_fault) |-> (resp_paddr[OFF_W-1:0] == acc_off_q));

    // R3: a faulted response carries no address
    a_r3_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_page_fault || resp_prot_fault) |-> (resp_valid && resp_paddr == '0));

    // R4: a hit answers exactly one cycle after acceptance
    a_r4_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> $past(req_valid && !busy));

    // R5: a busy cycle ends with a non-hit response and busy released
    a_r5_walk_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (resp_valid && !resp_hit && !busy));

    // R8: protection fault and page fault never coincide
    a_r8_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        resp_prot_fault |-> !resp_page_fault);

endmodule

bind pxl_xlate pxl_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_addr        (req_addr),
    .busy            (busy),
    .resp_valid      (resp_valid),
    .resp_paddr      (resp_paddr),
    .resp_hit        (resp_hit),
    .resp_page_fault (resp_page_fault),
    .resp_prot_fault (resp_prot_fault)
);

// File: tb/pxl_xlate_bench.sv
module pxl_xlate_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pt_we = 1'b0;
    logic [2:0] pt_widx = '0;
    logic [2:0] pt_wpfn = '0;
    logic       pt_wpresent = 1'b0;
    logic       pt_wwritable = 1'b0;
    logic       pt_wlock = 1'b0;
    logic [2:0] pt_qidx = '0;
    logic       pt_qref, pt_qmod, pt_qlock;
    logic       tlb_flush = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_addr = '0;
    logic       req_write = 1'b0;
    logic       busy, resp_valid, resp_hit, resp_page_fault, resp_prot_fault;
    logic [7:0] resp_paddr;

    always #10 clk = ~clk;

    pxl_xlate u_pxl_xlate (
        .clk(clk), .rst_n(rst_n),
        .pt_we(pt_we), .pt_widx(pt_widx), .pt_wpfn(pt_wpfn),
        .pt_wpresent(pt_wpresent), .pt_wwritable(pt_wwritable), .pt_wlock(pt_wlock),
        .pt_qidx(pt_qidx), .pt_qref(pt_qref), .pt_qmod(pt_qmod), .pt_qlock(pt_qlock),
        .tlb_flush(tlb_flush),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .busy(busy), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_hit(resp_hit), .resp_page_fault(resp_page_fault), .resp_prot_fault(resp_prot_fault)
    );

    typedef struct {
        logic [7:0] paddr;
        logic       hit;
        logic       pf;
        logic       prot;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare each response
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6 unexpected response", {resp_paddr, resp_hit, resp_page_fault, resp_prot_fault}, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({resp_paddr, resp_hit, resp_page_fault, resp_prot_fault} == {e.paddr, e.hit, e.pf, e.prot},
                      e.tag, {resp_paddr, resp_hit, resp_page_fault, resp_prot_fault},
                      {e.paddr, e.hit, e.pf, e.prot});
            end
        end
    end

    // mode 0: plain, 1: stray request during walk, 2: flush during walk
    task automatic access(input logic [7:0] a, input logic wr, input logic [7:0] epa,
                          input logic ehit, input logic epf, input logic eprot,
                          input string tag, input int mode = 0, input logic [7:0] stray = 8'h00);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = wr;
        e.paddr = epa; e.hit = ehit; e.pf = epf; e.prot = eprot; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        if (mode != 0) begin
            check(busy == 1'b1, "R5 busy during walk", busy, 1);
            if (mode == 1) begin
                req_valid = 1'b1;
                req_addr  = stray;
                req_write = 1'b0;
            end else begin
                tlb_flush = 1'b1;
            end
            @(negedge clk);
            req_valid = 1'b0;
            tlb_flush = 1'b0;
        end
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pt_write(input logic [2:0] idx, input logic [2:0] pfn,
                            input logic pres, input logic wrok, input logic lck);
        @(negedge clk);
        pt_we = 1'b1; pt_widx = idx; pt_wpfn = pfn;
        pt_wpresent = pres; pt_wwritable = wrok; pt_wlock = lck;
        @(negedge clk);
        pt_we = 1'b0;
    endtask

    task automatic peek(input logic [2:0] idx, input logic eref, input logic emod,
                        input logic elock, input string tag);
        drain();
        pt_qidx = idx;
        #1;
        check({pt_qref, pt_qmod, pt_qlock} == {eref, emod, elock}, tag,
              {pt_qref, pt_qmod, pt_qlock}, {eref, emod, elock});
    endtask

    task automatic flush();
        drain();
        tlb_flush = 1'b1;
        @(negedge clk);
        tlb_flush = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(resp_valid == 1'b0, "R1 resp_valid after reset", resp_valid, 0);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);

        pt_write(3'd0, 3'd5, 1'b1, 1'b0, 1'b1);
        pt_write(3'd1, 3'd2, 1'b1, 1'b1, 1'b0);
        pt_write(3'd2, 3'd3, 1'b0, 1'b1, 1'b0);
        pt_write(3'd3, 3'd7, 1'b1, 1'b1, 1'b0);
        pt_write(3'd4, 3'd1, 1'b1, 1'b1, 1'b0);
        pt_write(3'd5, 3'd3, 1'b1, 1'b1, 1'b0);
        pt_write(3'd6, 3'd0, 1'b1, 1'b1, 1'b0);
        pt_write(3'd7, 3'd6, 1'b1, 1'b1, 1'b0);

        access(8'h2A, 1'b0, 8'h4A, 1'b0, 1'b0, 1'b0, "R1 R2 R5 first miss 0x2A", 1, 8'h00);
        access(8'h3F, 1'b1, 8'h5F, 1'b1, 1'b0, 1'b0, "R4 hit write 0x3F");
        peek(3'd1, 1'b1, 1'b1, 1'b0, "R9 page1 ref/mod after write");

        access(8'h05, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0, "R2 page0 read miss");
        access(8'h07, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, "R8 write read-only hit");
        peek(3'd0, 1'b1, 1'b0, 1'b1, "R9 page0 no mod on faulted write, lock kept");

        access(8'h41, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R3 absent page");
        access(8'h41, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R3 absent page not cached");
        peek(3'd2, 1'b0, 1'b0, 1'b0, "R9 absent page untouched");

        pt_write(3'd1, 3'd4, 1'b1, 1'b1, 1'b0);
        peek(3'd1, 1'b0, 1'b0, 1'b0, "R9 descriptor write clears flags");
        access(8'h20, 1'b0, 8'h40, 1'b1, 1'b0, 1'b0, "R4 stale cached frame");
        peek(3'd1, 1'b1, 1'b0, 1'b0, "R9 hit sets referenced");

        flush();
        access(8'h20, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0, "R10 miss after flush");

        access(8'h61, 1'b0, 8'hE1, 1'b0, 1'b0, 1'b0, "R7 fill slot1");
        access(8'h82, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, "R7 fill slot2");
        access(8'hA3, 1'b0, 8'h63, 1'b0, 1'b0, 1'b0, "R7 fill slot3");
        access(8'hE4, 1'b0, 8'hC4, 1'b0, 1'b0, 1'b0, "R7 fill slot0");
        access(8'h61, 1'b0, 8'hE1, 1'b1, 1'b0, 1'b0, "R7 page3 still cached");
        access(8'h20, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0, "R7 page1 evicted");
        access(8'h82, 1'b0, 8'h22, 1'b1, 1'b0, 1'b0, "R7 page4 still cached");
        access(8'hA3, 1'b0, 8'h63, 1'b1, 1'b0, 1'b0, "R7 page5 still cached");

        flush();
        access(8'hE5, 1'b0, 8'hC5, 1'b0, 1'b0, 1'b0, "R6 miss with stray", 1, 8'h21);
        access(8'h21, 1'b0, 8'h81, 1'b0, 1'b0, 1'b0, "R6 stray page not cached");
        access(8'hE5, 1'b0, 8'hC5, 1'b1, 1'b0, 1'b0, "R5 filled page hits");

        flush();
        access(8'hC6, 1'b0, 8'h06, 1'b0, 1'b0, 1'b0, "R10 miss with flush in walk", 2);
        access(8'hC6, 1'b0, 8'h06, 1'b0, 1'b0, 1'b0, "R10 flush beat fill");
        access(8'hC6, 1'b0, 8'h06, 1'b1, 1'b0, 1'b0, "R5 later fill hits");

        flush();
        access(8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, "R8 write read-only miss");
        access(8'h01, 1'b0, 8'hA1, 1'b1, 1'b0, 1'b0, "R8 protected miss still filled");

        drain();
        check(sb.size() == 0, "R6 no pending responses", sb.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule